// File: doc/BRIEF.md
# Byte-prefixed I2C control register slave

This block is a write-only I2C target that sits beside an audio mixing and amplifier datapath and holds its control settings. It oversamples the SCL and SDA pins with the fast system clock. It answers one fixed 7-bit address and only in write direction, then accepts any number of data bytes until STOP. No register pointer is sent. Each data byte names its own destination through a prefix of 2 or 3 leading bits. The remaining bits of the byte are the new field values for that register. The block acknowledges every byte it takes by pulling SDA low during the ninth clock. Every field is driven as a parallel output.

The controller is a state machine with six named states. IDLE waits for START. ADDR shifts in the address byte. ADDR_ACK holds SDA low for an accepted address. DATA shifts in a data byte. DATA_ACK holds SDA low and commits the byte. IGNORE waits out a transaction that was not meant for this target.

The transitions are as follows. Any state goes to ADDR on START, and any state goes to IDLE on STOP. ADDR goes to ADDR_ACK after eight bits when the byte equals 0x88, and to IGNORE otherwise. DATA goes to DATA_ACK after eight bits. Both acknowledge states go to DATA on the SCL falling edge that ends the ninth clock.

Top module: `ctlreg_i2c_slave`

## Requirements
- R1: After reset, the outputs hold the following values. Both attenuation registers are coarse 7 and fine 7 (mute). Both gain fields are 0 and both line selects are 0 (line 1). The power outputs are dac_pd=1, rch_pd=1, lch_pd=1, off_prep=0 and ref_pulldown=1. The mode outputs are se_mode=0 (BTL), mix_l=0, mix_r=0 and audio_fmt=00 (right-justified). sda_drive_low is 0.
- R2: After a START, an address byte of 0x88 (7-bit address 0x44 with the R/W bit at 0) is acknowledged: sda_drive_low is 1 during the ninth SCL high phase.
- R3: Any number of data bytes may follow the address in one transaction. Each byte is acknowledged and applied in order, and each register keeps its value until a byte with its prefix arrives.
- R4: A data byte with bits[7:6]=00 writes the left attenuation and 01 writes the right attenuation. In both cases coarse = bits[5:3] (10 dB steps) and fine = bits[2:0] (1.25 dB steps).
- R5: A data byte with bits[7:5]=100 writes the left input register and 101 writes the right one. In both cases gain = bits[4:2] (3 dB steps) and line select = bits[1:0].
- R6: A data byte with bits[7:5]=110 writes the power register. The fields are dac_pd=bit4, rch_pd=bit3, lch_pd=bit2, off_prep=bit1 and ref_pulldown=bit0.
- R7: A data byte with bits[7:5]=111 writes the mode register. The fields are se_mode=bit4, mix_l=bit3, mix_r=bit2 and audio_fmt=bits[1:0].
- R8: If the address byte differs from 0x88, whether in the address or in the R/W bit, it is not acknowledged. The bytes that follow are neither acknowledged nor applied until the next START.
- R9: A data byte cut short by STOP or by a repeated START changes no register. A repeated START begins a fresh address phase.
- R10: sda_drive_low changes only while SCL is low, and it is released after the SCL falling edge that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_drive_low | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| att_l_coarse | output | 3 | Left attenuation, 10 dB steps |
| att_l_fine | output | 3 | Left attenuation, 1.25 dB steps |
| att_r_coarse | output | 3 | Right attenuation, 10 dB steps |
| att_r_fine | output | 3 | Right attenuation, 1.25 dB steps |
| gain_l | output | 3 | Left input gain, 3 dB steps |
| line_l | output | 2 | Left input line select |
| gain_r | output | 3 | Right input gain, 3 dB steps |
| line_r | output | 2 | Right input line select |
| dac_pd | output | 1 | Converter power-down |
| rch_pd | output | 1 | Right amplifier power-down |
| lch_pd | output | 1 | Left amplifier power-down |
| off_prep | output | 1 | Power-off preparation |
| ref_pulldown | output | 1 | Pull the reference node to ground |
| se_mode | output | 1 | 1 = single-ended, 0 = bridged output |
| mix_l | output | 1 | Mix converter into left path |
| mix_r | output | 1 | Mix converter into right path |
| audio_fmt | output | 2 | Serial audio format code |

## Verification
The assertions assume that SCL stays low for more than a few system clocks after each falling edge. Under that assumption the acknowledge edges, which arrive through the synchronizer, fall inside the low phase of the raw pin. The bench meets this by holding every SCL phase for ten system clocks. It also changes SDA only while SCL is low, except at START and STOP. The bench models the open-drain line as the AND of its own drive and the block's pull-down. It applies all pin changes three nanoseconds past a clock edge.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } bus_state_t;

    typedef struct packed {
        logic [2:0] coarse;
        logic [2:0] fine;
    } atten_t;

    typedef struct packed {
        logic [2:0] gain;
        logic [1:0] line;
    } insel_t;

    typedef struct packed {
        logic dac_pd;
        logic rch_pd;
        logic lch_pd;
        logic off_prep;
        logic ref_pulldown;
    } power_t;

    typedef struct packed {
        logic       se_mode;
        logic       mix_l;
        logic       mix_r;
        logic [1:0] fmt;
    } outmode_t;

    localparam atten_t   ATTEN_RST = '{coarse: 3'b111, fine: 3'b111};
    localparam insel_t   INSEL_RST = '{gain: 3'b000, line: 2'b00};
    localparam power_t   POWER_RST = '{dac_pd: 1'b1, rch_pd: 1'b1, lch_pd: 1'b1,
                                       off_prep: 1'b0, ref_pulldown: 1'b1};
    localparam outmode_t MODE_RST  = '{se_mode: 1'b0, mix_l: 1'b0, mix_r: 1'b0, fmt: 2'b00};

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_d, sda_d;
    logic              scl_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[LAST];
            sda_d <= sda_q[LAST];
        end
    end

    assign scl_now   = scl_q[LAST];
    assign sda_s     = sda_q[LAST];
    assign scl_rise  = scl_now & ~scl_d;
    assign scl_fall  = ~scl_now & scl_d;
    assign start_det = scl_now & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_now & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
    import ctlreg_pkg::*;
#(
    parameter int unsigned DEV_ADDR = 'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              ack_drive,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_byte
);
    localparam int                CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0]  FULL    = CNT_W'(BYTE_W);
    localparam logic [BYTE_W-1:0] ADDR_WR = BYTE_W'(DEV_ADDR << 1);

    bus_state_t        state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              byte_done;

    assign byte_done = scl_fall && (bit_cnt == FULL);

    // next-state decision
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: state_nx = state;
                ST_ADDR: if (byte_done)
                             state_nx = (shreg == ADDR_WR) ? ST_ADDR_ACK : ST_IGNORE;
                ST_DATA: if (byte_done) state_nx = ST_DATA_ACK;
                ST_ADDR_ACK, ST_DATA_ACK: if (scl_fall) state_nx = ST_DATA;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // bit framing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (start_det || stop_det || byte_done) begin
            bit_cnt <= '0;
        end else if ((state == ST_ADDR || state == ST_DATA) && scl_rise && bit_cnt != FULL) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        ack_drive = (state == ST_ADDR_ACK) || (state == ST_DATA_ACK);
        wr_stb    = (state == ST_DATA_ACK) && scl_rise && !start_det && !stop_det;
        wr_byte   = shreg;
    end

endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
    import ctlreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    output atten_t            att_l,
    output atten_t            att_r,
    output insel_t            insel_l,
    output insel_t            insel_r,
    output power_t            power,
    output outmode_t          mode
);
    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        atten_t att_q;
        insel_t sel_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                att_q <= ATTEN_RST;
                sel_q <= INSEL_RST;
            end else if (wr_stb) begin
                if (wr_byte[7:6] == {1'b0, 1'(ch)})
                    att_q <= atten_t'(wr_byte[5:0]);
                if (wr_byte[7:5] == {2'b10, 1'(ch)})
                    sel_q <= insel_t'(wr_byte[4:0]);
            end
        end
    end

    assign att_l   = g_ch[0].att_q;
    assign att_r   = g_ch[1].att_q;
    assign insel_l = g_ch[0].sel_q;
    assign insel_r = g_ch[1].sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            power <= POWER_RST;
            mode  <= MODE_RST;
        end else if (wr_stb) begin
            unique case (wr_byte[7:5])
                3'b110:  power <= power_t'(wr_byte[4:0]);
                3'b111:  mode  <= outmode_t'(wr_byte[4:0]);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ctlreg_i2c_slave.sv
module ctlreg_i2c_slave
    import ctlreg_pkg::*;
#(
    parameter int unsigned DEV_ADDR    = 'h44,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_drive_low,
    output logic [2:0] att_l_coarse,
    output logic [2:0] att_l_fine,
    output logic [2:0] att_r_coarse,
    output logic [2:0] att_r_fine,
    output logic [2:0] gain_l,
    output logic [1:0] line_l,
    output logic [2:0] gain_r,
    output logic [1:0] line_r,
    output logic       dac_pd,
    output logic       rch_pd,
    output logic       lch_pd,
    output logic       off_prep,
    output logic       ref_pulldown,
    output logic       se_mode,
    output logic       mix_l,
    output logic       mix_r,
    output logic [1:0] audio_fmt
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_stb;
    logic [BYTE_W-1:0] wr_byte;
    atten_t            att_l, att_r;
    insel_t            insel_l, insel_r;
    power_t            power;
    outmode_t          mode;

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_byte_fsm #(.DEV_ADDR(DEV_ADDR)) fsm_i (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .ack_drive(sda_drive_low), .wr_stb(wr_stb), .wr_byte(wr_byte)
    );

    ctlreg_bank bank_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_byte(wr_byte),
        .att_l(att_l), .att_r(att_r), .insel_l(insel_l), .insel_r(insel_r),
        .power(power), .mode(mode)
    );

    assign att_l_coarse = att_l.coarse;
    assign att_l_fine   = att_l.fine;
    assign att_r_coarse = att_r.coarse;
    assign att_r_fine   = att_r.fine;
    assign gain_l       = insel_l.gain;
    assign line_l       = insel_l.line;
    assign gain_r       = insel_r.gain;
    assign line_r       = insel_r.line;
    assign dac_pd       = power.dac_pd;
    assign rch_pd       = power.rch_pd;
    assign lch_pd       = power.lch_pd;
    assign off_prep     = power.off_prep;
    assign ref_pulldown = power.ref_pulldown;
    assign se_mode      = mode.se_mode;
    assign mix_l        = mode.mix_l;
    assign mix_r        = mode.mix_r;
    assign audio_fmt    = mode.fmt;

endmodule

// File: rtl/ctlreg_chk.sv
module ctlreg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_drive_low,
    input logic        wr_stb,
    input logic [11:0] att_pair,
    input logic [9:0]  sel_pair,
    input logic [4:0]  pwr,
    input logic [4:0]  mode
);
    // R10
    ack_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_drive_low) || $fell(sda_drive_low)) |-> !scl_i);

    // R3
    commit_inside_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> sda_drive_low);

    // R3
    hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable({att_pair, sel_pair, pwr, mode}));

    // R4
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!$stable(att_pair[11:6]), !$stable(att_pair[5:0]),
                  !$stable(sel_pair[9:5]), !$stable(sel_pair[4:0]),
                  !$stable(pwr), !$stable(mode)}));

endmodule

bind ctlreg_i2c_slave ctlreg_chk chk_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_drive_low(sda_drive_low),
    .wr_stb(wr_stb),
    .att_pair({att_l_coarse, att_l_fine, att_r_coarse, att_r_fine}),
    .sel_pair({gain_l, line_l, gain_r, line_r}),
    .pwr({dac_pd, rch_pd, lch_pd, off_prep, ref_pulldown}),
    .mode({se_mode, mix_l, mix_r, audio_fmt})
);

// File: tb/ctlreg_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module ctlreg_i2c_slave_tb_top;
    localparam int Q = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive_low;
    logic [2:0] att_l_coarse, att_l_fine, att_r_coarse, att_r_fine, gain_l, gain_r;
    logic [1:0] line_l, line_r, audio_fmt;
    logic dac_pd, rch_pd, lch_pd, off_prep, ref_pulldown, se_mode, mix_l, mix_r;
    logic sda_line;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    assign sda_line = sda_m & ~sda_drive_low;

    always #5 clk = ~clk;

    ctlreg_i2c_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_drive_low(sda_drive_low),
        .att_l_coarse(att_l_coarse), .att_l_fine(att_l_fine),
        .att_r_coarse(att_r_coarse), .att_r_fine(att_r_fine),
        .gain_l(gain_l), .line_l(line_l), .gain_r(gain_r), .line_r(line_r),
        .dac_pd(dac_pd), .rch_pd(rch_pd), .lch_pd(lch_pd), .off_prep(off_prep),
        .ref_pulldown(ref_pulldown), .se_mode(se_mode), .mix_l(mix_l),
        .mix_r(mix_r), .audio_fmt(audio_fmt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q;
        acked = ~sda_line;
        #Q; scl_m = 1'b0; #Q;
    endtask

    function automatic logic [11:0] att_now();
        return {att_l_coarse, att_l_fine, att_r_coarse, att_r_fine};
    endfunction

    task automatic t_reset();
        chk("R1 att", 32'(att_now()), 32'hFFF);
        chk("R1 insel", 32'({gain_l, line_l, gain_r, line_r}), 32'h0);
        chk("R1 power", 32'({dac_pd, rch_pd, lch_pd, off_prep, ref_pulldown}), 32'b11101);
        chk("R1 mode", 32'({se_mode, mix_l, mix_r, audio_fmt}), 32'h0);
        chk("R1 sda", 32'(sda_drive_low), 32'h0);
    endtask

    task automatic t_address();
        logic a;
        bus_start();
        send_byte(8'h88, a);
        chk("R2 address ack", 32'(a), 32'h1);
        chk("R10 released after ninth clock", 32'(sda_drive_low), 32'h0);
        bus_stop();
    endtask

    task automatic t_atten();
        logic a0, a1, a2;
        bus_start();
        send_byte(8'h88, a0);
        send_byte(8'h2B, a1);
        send_byte(8'h41, a2);
        bus_stop();
        chk("R3 data acks", 32'({a0, a1, a2}), 32'h7);
        chk("R4 left atten", 32'({att_l_coarse, att_l_fine}), 32'o53);
        chk("R4 right atten", 32'({att_r_coarse, att_r_fine}), 32'o01);
    endtask

    task automatic t_insel();
        logic a0, a1, a2;
        bus_start();
        send_byte(8'h88, a0);
        send_byte(8'h87, a1);
        send_byte(8'hA6, a2);
        bus_stop();
        chk("R5 left gain/line", 32'({gain_l, line_l}), 32'b00111);
        chk("R5 right gain/line", 32'({gain_r, line_r}), 32'b00110);
        chk("R3 attenuation kept", 32'(att_now()), 32'o5301);
    endtask

    task automatic t_power_mode();
        logic a0, a1, a2;
        bus_start();
        send_byte(8'h88, a0);
        send_byte(8'hD5, a1);
        send_byte(8'hFD, a2);
        bus_stop();
        chk("R6 power", 32'({dac_pd, rch_pd, lch_pd, off_prep, ref_pulldown}), 32'b10101);
        chk("R7 mode", 32'({se_mode, mix_l, mix_r, audio_fmt}), 32'b11101);
        bus_start();
        send_byte(8'h88, a0);
        send_byte(8'hC0, a1);
        bus_stop();
        chk("R6 power cleared", 32'({dac_pd, rch_pd, lch_pd, off_prep, ref_pulldown}), 32'h0);
        chk("R7 mode kept", 32'({se_mode, mix_l, mix_r, audio_fmt}), 32'b11101);
    endtask

    task automatic t_foreign();
        logic a0, a1;
        bus_start();
        send_byte(8'h8A, a0);
        send_byte(8'h00, a1);
        bus_stop();
        chk("R8 wrong address nack", 32'({a0, a1}), 32'h0);
        chk("R8 wrong address ignored", 32'(att_now()), 32'o5301);
        bus_start();
        send_byte(8'h89, a0);
        send_byte(8'h80, a1);
        bus_stop();
        chk("R8 read bit nack", 32'({a0, a1}), 32'h0);
        chk("R8 read ignored", 32'({gain_l, line_l}), 32'b00111);
    endtask

    task automatic t_cut();
        logic a0, a1;
        bus_start();
        send_byte(8'h88, a0);
        send_bits(8'h00, 4);
        bus_stop();
        chk("R9 partial byte at STOP", 32'(att_now()), 32'o5301);
        bus_start();
        send_byte(8'h88, a0);
        send_bits(8'h7F, 3);
        bus_start();
        chk("R9 partial byte at repeated START", 32'(att_now()), 32'o5301);
        send_byte(8'h88, a0);
        send_byte(8'h00, a1);
        bus_stop();
        chk("R9 fresh address after repeated START", 32'({a0, a1}), 32'h3);
        chk("R9 write after repeated START", 32'({att_l_coarse, att_l_fine}), 32'h0);
    endtask

    initial begin
        #3;
        #50 rst_n = 1'b1;
        #Q;
        t_reset();
        t_address();
        t_atten();
        t_insel();
        t_power_mode();
        t_foreign();
        t_cut();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule